// File: doc/BRIEF.md
# Read Prefetch Count Controller

This block sets how far ahead a bridge reads from prefetchable memory on behalf of a waiting initiator. It counts doublewords only and never sees the data itself. A read opens with a start strobe, which also captures three programmed counts: the opening block size, the top-up step and the ceiling. From then on the block keeps three running totals: doublewords requested from the target, doublewords delivered by the target, and doublewords taken by the initiator.

The first request reaches only the next boundary aligned to the opening block size, so a read that starts partway into a region fetches less at first. After that, whenever the requested-but-unconsumed amount drops below the top-up step, one more step is requested. This repeats until the total reaches the ceiling. A termination that arrives after the initiator has taken data ends the prefetch. Every input is a single-cycle strobe or a level. There is no valid/ready pair and no back-pressure: a beat strobe is counted in the cycle it is seen, or it is dropped under the rules below.

Top module: `rdpf_ctrl`

## Requirements
- R1: After reset, fetch_en, outstanding and done are all 0.
- R2: A start strobe captures incr_cnt and max_cnt and clears the delivered and consumed totals. It sets the requested total to P minus (start_ofs modulo P), capped at max_cnt. P is the highest set bit of init_cnt taken as a power of two, and an init_cnt of 0 counts as 1. Beat and termination strobes in the same cycle as start have no effect.
- R3: outstanding equals requested minus delivered. fetch_en is 1 exactly when a read is running, is not done, and outstanding is nonzero.
- R4: A fetch_beat strobe is ignored when outstanding is 0, when done is set, or before any start. A take_beat strobe is ignored when no delivered doubleword is left unconsumed.
- R5: When requested minus consumed is below the captured step and requested is below the ceiling, the next clock adds the smaller of the step and (ceiling minus requested).
- R6: Top-up is off for the whole read when the step is 0 or is greater than or equal to the ceiling.
- R7: The delivered total never exceeds the ceiling. On the clock edge where it reaches the ceiling, done rises and fetch_en falls.
- R8: A term strobe while running, once at least one doubleword has been consumed, sets done and drops outstanding to 0. No more fetch beats are counted after that.
- R9: A term strobe before any doubleword has been consumed has no effect, and the read keeps fetching.
- R10: done stays set until the next start strobe, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_cnt | input | CW | Opening block size in doublewords |
| incr_cnt | input | CW | Top-up step in doublewords |
| max_cnt | input | CW | Ceiling on total doublewords fetched |
| start | input | 1 | Strobe that opens a new read |
| start_ofs | input | CW | Doubleword offset of the start address |
| fetch_beat | input | 1 | One doubleword delivered by the target |
| take_beat | input | 1 | One doubleword taken by the initiator |
| term | input | 1 | Initiator ended the transaction |
| fetch_en | output | 1 | More doublewords are wanted from the target |
| outstanding | output | CW | Doublewords requested but not yet delivered |
| done | output | 1 | Prefetch for this read is finished |

## Verification
The opening request is tested with an aligned start, a mid-region offset, an offset wrapping past one region, an init_cnt that is not a power of two, a zero init_cnt, and a ceiling below the opening size. Each case separates the encoder, the offset mask and the cap. A paced fetch-and-consume sequence finds the exact cycle a top-up appears, which tells a strict below-step comparison from a non-strict one. A full run with a ceiling that is not a multiple of the step checks the clipped final top-up. Surplus beats, terminations with and without a prior transfer, and a restart over a finished read separate the ignore rules from the ones that change state.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;
  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_RUN  = 2'd1,
    PF_DONE = 2'd2
  } pf_state_e;
endpackage

// File: rtl/rdpf_first_len.sv
module rdpf_first_len #(
  parameter int CW = 12
) (
  input  logic [CW-1:0] init_cnt,
  input  logic [CW-1:0] start_ofs,
  input  logic [CW-1:0] max_cnt,
  output logic [CW-1:0] first_len
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] blk;
  logic [CW-1:0] into;
  logic [CW-1:0] span;

  // keep only the highest set bit; zero counts as one doubleword
  always_comb begin
    blk = ONE;
    for (int i = 0; i < CW; i++) begin
      if (init_cnt[i]) blk = ONE << i;
    end
  end

  assign into = start_ofs & (blk - ONE);
  assign span = blk - into;
  assign first_len = (span > max_cnt) ? max_cnt : span;
endmodule

// File: rtl/rdpf_topup.sv
module rdpf_topup #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          running,
  input  logic [CW-1:0] req_tot,
  input  logic [CW-1:0] con_tot,
  input  logic [CW-1:0] step,
  input  logic [CW-1:0] ceil,
  output logic          add_en,
  output logic [CW-1:0] add_len
);
  logic          step_ok;
  logic [CW-1:0] left;
  logic [CW-1:0] room;

  assign step_ok = (step != '0) && (step < ceil);
  assign left    = req_tot - con_tot;
  assign room    = ceil - req_tot;
  assign add_en  = running && step_ok && (left < step) && (req_tot < ceil);
  assign add_len = (room < step) ? room : step;

  // R5: a top-up is never empty and never larger than the step
  assert_topup_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |-> (add_len != '0) && (add_len <= step));
  // R6: top-up never fires when the step is out of range
  assert_topup_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step >= ceil) |-> !add_en);
endmodule

// File: rtl/rdpf_tally.sv
module rdpf_tally #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rdpf_ctrl.sv
module rdpf_ctrl #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] init_cnt,
  input  logic [CW-1:0] incr_cnt,
  input  logic [CW-1:0] max_cnt,
  input  logic          start,
  input  logic [CW-1:0] start_ofs,
  input  logic          fetch_beat,
  input  logic          take_beat,
  input  logic          term,
  output logic          fetch_en,
  output logic [CW-1:0] outstanding,
  output logic          done
);
  import rdpf_pkg::*;

  pf_state_e     st_q;
  logic [CW-1:0] step_q, ceil_q, req_q;
  logic [CW-1:0] fet_q, con_q, fet_nxt;
  logic [CW-1:0] first_len, add_len;
  logic          running, fet_inc, con_inc, term_ok, add_en;

  assign running = (st_q == PF_RUN);

  rdpf_first_len #(.CW(CW)) u_first (
    .init_cnt (init_cnt),
    .start_ofs(start_ofs),
    .max_cnt  (max_cnt),
    .first_len(first_len)
  );

  rdpf_topup #(.CW(CW)) u_topup (
    .clk    (clk),
    .rst_n  (rst_n),
    .running(running),
    .req_tot(req_q),
    .con_tot(con_q),
    .step   (step_q),
    .ceil   (ceil_q),
    .add_en (add_en),
    .add_len(add_len)
  );

  assign fet_inc = !start && running && (req_q != fet_q) && fetch_beat;
  assign con_inc = !start && (st_q != PF_IDLE) && (fet_q != con_q) && take_beat;
  assign term_ok = !start && running && term && (con_q != '0);
  assign fet_nxt = fet_q + {{(CW-1){1'b0}}, fet_inc};

  rdpf_tally #(.CW(CW)) u_fet (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(fet_inc), .cnt(fet_q)
  );

  rdpf_tally #(.CW(CW)) u_con (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(con_inc), .cnt(con_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= PF_IDLE;
      step_q <= '0;
      ceil_q <= '0;
      req_q  <= '0;
    end else if (start) begin
      st_q   <= PF_RUN;
      step_q <= incr_cnt;
      ceil_q <= max_cnt;
      req_q  <= first_len;
    end else if (running) begin
      if (term_ok) begin
        st_q  <= PF_DONE;
        req_q <= fet_nxt;
      end else begin
        if (fet_nxt == ceil_q) st_q <= PF_DONE;
        if (add_en) req_q <= req_q + add_len;
      end
    end
  end

  assign fetch_en    = running && (req_q != fet_q);
  assign outstanding = req_q - fet_q;
  assign done        = (st_q == PF_DONE);

  // R7: requested total stays under the ceiling
  assert_req_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q <= ceil_q);
  // R4: delivered never passes requested, consumed never passes delivered
  assert_fet_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fet_q <= req_q);
  assert_con_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    con_q <= fet_q);
  // R8: a finished read asks for nothing
  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fetch_en && (outstanding == '0));
  // R10: done holds until the next start
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R2: start clears the running totals
  assert_start_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (fet_q == '0) && (con_q == '0) && !done);
endmodule

// File: tb/sim_rdpf_ctrl.sv
module sim_rdpf_ctrl;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] init_cnt = '0, incr_cnt = '0, max_cnt = '0, start_ofs = '0;
  logic          start = 1'b0, fetch_beat = 1'b0, take_beat = 1'b0, term = 1'b0;
  logic          fetch_en, done;
  logic [CW-1:0] outstanding;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rdpf_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .init_cnt(init_cnt), .incr_cnt(incr_cnt),
    .max_cnt(max_cnt), .start(start), .start_ofs(start_ofs),
    .fetch_beat(fetch_beat), .take_beat(take_beat), .term(term),
    .fetch_en(fetch_en), .outstanding(outstanding), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    start = 0; fetch_beat = 0; take_beat = 0; term = 0;
  endtask

  task automatic open_read(input int ini, input int inc, input int mx, input int ofs);
    init_cnt = CW'(ini); incr_cnt = CW'(inc); max_cnt = CW'(mx); start_ofs = CW'(ofs);
    start = 1;
    step();
  endtask

  task automatic fetch_n(input int n);
    for (int i = 0; i < n; i++) begin fetch_beat = 1; step(); end
  endtask

  task automatic take_n(input int n);
    for (int i = 0; i < n; i++) begin take_beat = 1; step(); end
  endtask

  task automatic t_reset();
    check("R1 fetch_en", fetch_en, 0);
    check("R1 outstanding", outstanding, 0);
    check("R1 done", done, 0);
    fetch_n(1);
    check("R4 beat before start", outstanding, 0);
  endtask

  task automatic t_first_len();
    open_read(16, 4, 64, 5);
    check("R2 offset 5 of 16", outstanding, 11);
    check("R3 fetch_en", fetch_en, 1);
    open_read(16, 4, 64, 19);
    check("R2 offset 19 of 16", outstanding, 13);
    open_read(12, 4, 64, 0);
    check("R2 non power init", outstanding, 8);
    open_read(0, 4, 64, 3);
    check("R2 zero init", outstanding, 1);
    open_read(16, 4, 10, 0);
    check("R2 capped by max", outstanding, 10);
  endtask

  task automatic t_topup_step();
    open_read(8, 4, 20, 0);
    fetch_n(8);
    check("R3 all delivered", outstanding, 0);
    check("R3 fetch_en low", fetch_en, 0);
    take_n(5);
    check("R5 no top-up yet", outstanding, 0);
    step();
    check("R5 top-up added", outstanding, 4);
    check("R5 fetch_en again", fetch_en, 1);
  endtask

  task automatic t_run_ceiling();
    int bf = 0;
    int bc = 0;
    open_read(8, 4, 18, 0);
    for (int i = 0; i < 200 && !done; i++) begin
      int fb;
      int tb;
      fb = fetch_en ? 1 : 0;
      tb = (bf > bc) ? 1 : 0;
      fetch_beat = fb[0]; take_beat = tb[0];
      step();
      bf += fb; bc += tb;
    end
    check("R7 total at ceiling", bf, 18);
    check("R7 done", done, 1);
    check("R7 fetch_en low", fetch_en, 0);
  endtask

  task automatic t_incr_off();
    open_read(4, 8, 5, 0);
    fetch_n(4);
    fetch_n(2);
    check("R4 surplus beats ignored", done, 0);
    take_n(4);
    take_n(1);
    step(); step();
    check("R6 no top-up", outstanding, 0);
    check("R6 fetch_en low", fetch_en, 0);
    open_read(4, 0, 16, 0);
    fetch_n(4);
    take_n(4);
    step(); step();
    check("R6 zero step", outstanding, 0);
  endtask

  task automatic t_term_xfer();
    open_read(8, 4, 32, 0);
    fetch_n(3);
    take_n(1);
    term = 1;
    step();
    check("R8 done", done, 1);
    check("R8 outstanding", outstanding, 0);
    check("R8 fetch_en", fetch_en, 0);
    fetch_n(1);
    step(); step();
    check("R10 still done", done, 1);
    check("R8 no refetch", outstanding, 0);
  endtask

  task automatic t_term_none();
    open_read(8, 4, 32, 0);
    fetch_n(2);
    term = 1;
    step();
    check("R9 done", done, 0);
    check("R9 outstanding", outstanding, 6);
    check("R9 fetch_en", fetch_en, 1);
  endtask

  task automatic t_restart();
    open_read(8, 4, 32, 0);
    fetch_n(1); take_n(1);
    term = 1; step();
    check("R10 done before restart", done, 1);
    fetch_beat = 1;
    open_read(4, 2, 10, 0);
    check("R10 done cleared", done, 0);
    check("R2 start wins over beat", outstanding, 4);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_first_len();
    t_topup_step();
    t_run_ceiling();
    t_incr_off();
    t_term_xfer();
    t_term_none();
    t_restart();
    finish_run();
  end
endmodule